// File: doc/BRIEF.md
# Requester ID to StreamID Translation Table

This block converts the 16-bit Requester ID carried by a PCIe requester into the 6-bit StreamID used by an IOMMU and by an MSI interrupt translator. It holds 32 translation entries. Each entry has a valid flag, a stored Requester ID, a 16-bit match mask, a 6-bit StreamID and a 3-bit controller ID. An incoming ID hits an entry when it equals the stored ID in every bit where the mask is 1. A mask of all ones therefore matches one requester only, and a sparser mask covers a group of requesters, for example a whole bus.

Software never addresses an entry directly. It works through a staging pair of data registers and an access-control register. Writing the control word with the load bit set copies an entry into the staging pair. Writing it with the load bit clear stores the staging pair into an entry. To remove an entry, software stores zero into it.

The lookup port takes a strobe and an ID. One clock later it returns a valid pulse, a hit flag, the StreamID and the controller ID. A second output serves the MSI side: it places a fixed 2-bit source-controller code above the StreamID. The code is set by a parameter: 00 for the first PCIe controller, 01 for the Ethernet controller, 10 for the second PCIe controller.

Top module: `rsl_lut_top`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses, and the registers at 0x1008, 0x100C and 0x1010 read as zero.
- R2: The access-control register at 0x1008 holds the entry index in bits 4:0 and the load bit in bit 16. It reads back the last written index and load bit. Its other bits ignore writes and read as zero.
- R3: A write to 0x1008 with bit 16 set copies the indexed entry into both staging registers. The copy can be read back after that write.
- R4: A write to 0x1008 with bit 16 clear stores both staging registers into the indexed entry. Lookups from the next clock onward use the new contents.
- R5: Staging register 0x100C holds the valid flag in bit 31, the controller ID in bits 10:8 and the StreamID in bits 5:0. All other bits, including StreamID bits 7:6, ignore writes and read as zero, so a StreamID is never above 63.
- R6: Staging register 0x1010 holds the stored Requester ID in bits 31:16 and the match mask in bits 15:0. All 32 bits read back as written.
- R7: A lookup hits a valid entry when the incoming ID and the stored ID agree in every bit position where the entry's mask is 1. Bit positions where the mask is 0 are not compared.
- R8: When more than one valid entry hits, the entry with the lowest index supplies the result.
- R9: The result appears one clock after the request strobe, marked by `lk_valid`. On a miss, `lk_hit`, `lk_sid`, `lk_ctl` and `msi_sid` are all zero.
- R10: A lookup in the same clock as a store sees the entry's old contents.
- R11: Storing zero into both staging registers and committing them to an index removes that entry. Lookups then skip it, and a later load of that index reads zero.
- R12: On a hit, `msi_sid` equals the 2-bit source code in bits 7:6 above the StreamID in bits 5:0. `lk_sid` carries the StreamID alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| lk_req | input | 1 | Lookup request strobe |
| lk_rid | input | 16 | Requester ID to translate |
| lk_valid | output | 1 | Result valid, one clock after `lk_req` |
| lk_hit | output | 1 | A valid entry matched |
| lk_sid | output | 6 | StreamID for the IOMMU |
| lk_ctl | output | 3 | Controller ID of the matching entry |
| msi_sid | output | 8 | Source code above the StreamID, for the MSI side |

## Verification
Lookups are tried with four kinds of ID:
- an ID that hits both an exact entry and a masked entry, which shows whether the lower index wins;
- an ID that differs from the exact entry only in masked-off bits, which shows that masked bits are not compared;
- an ID that hits only at StreamID 63 and controller ID 7, which exposes truncated fields;
- an ID that hits nothing, which checks that every output is zero on a miss.

A lookup issued in the same clock as a store to a matching entry checks that the old contents are used. A repeat lookup in the next clock checks that the new contents are used. Removing an entry and then repeating a lookup shows whether the lookup falls through to the next matching entry. Loading entries back through the staging registers, and writing all-ones words to every register, separates the field layouts and the reserved bits.

// File: rtl/rsl_pkg.sv
package rsl_pkg;

    localparam int RID_W  = 16;
    localparam int SID_W  = 6;
    localparam int CTL_W  = 3;
    localparam int WORD_W = 32;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 16'h1008;
    localparam logic [ADDR_W-1:0] ADR_D1   = 16'h100C;
    localparam logic [ADDR_W-1:0] ADR_D2   = 16'h1010;

    localparam int CTRL_LOAD_BIT = 16;
    localparam int D1_VLD_BIT    = 31;
    localparam int D1_CTL_LSB    = 8;

    typedef enum logic [1:0] {
        SRC_PCIE_A = 2'b00,
        SRC_ENET   = 2'b01,
        SRC_PCIE_B = 2'b10
    } src_code_e;

    typedef struct packed {
        logic             vld;
        logic [CTL_W-1:0] ctl;
        logic [SID_W-1:0] sid;
        logic [RID_W-1:0] rid;
        logic [RID_W-1:0] msk;
    } rsl_entry_t;

    function automatic logic [WORD_W-1:0] d1_word(input rsl_entry_t e);
        logic [WORD_W-1:0] w;
        w = '0;
        w[D1_VLD_BIT] = e.vld;
        w[D1_CTL_LSB +: CTL_W] = e.ctl;
        w[SID_W-1:0] = e.sid;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] d2_word(input rsl_entry_t e);
        return {e.rid, e.msk};
    endfunction

    function automatic logic rid_match(input rsl_entry_t e, input logic [RID_W-1:0] rid);
        return e.vld && (((rid ^ e.rid) & e.msk) == '0);
    endfunction

endpackage

// File: rtl/rsl_regs.sv
module rsl_regs
    import rsl_pkg::*;
#(
    parameter int N_ENT = 32,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic [IDX_W-1:0]  rd_idx,
    input  rsl_entry_t        rd_entry,
    output logic              commit_en,
    output logic [IDX_W-1:0]  commit_idx,
    output rsl_entry_t        commit_entry
);

    logic             load_q;
    logic [IDX_W-1:0] idx_q;
    rsl_entry_t       stage_q;
    logic             ctrl_wr, d1_wr, d2_wr;

    assign ctrl_wr = reg_wr && (reg_addr == ADR_CTRL);
    assign d1_wr   = reg_wr && (reg_addr == ADR_D1);
    assign d2_wr   = reg_wr && (reg_addr == ADR_D2);

    assign rd_idx       = reg_wdata[IDX_W-1:0];
    assign commit_en    = ctrl_wr && !reg_wdata[CTRL_LOAD_BIT];
    assign commit_idx   = reg_wdata[IDX_W-1:0];
    assign commit_entry = stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q  <= 1'b0;
            idx_q   <= '0;
            stage_q <= '0;
        end else begin
            if (ctrl_wr) begin
                load_q <= reg_wdata[CTRL_LOAD_BIT];
                idx_q  <= reg_wdata[IDX_W-1:0];
                if (reg_wdata[CTRL_LOAD_BIT]) begin
                    stage_q <= rd_entry;
                end
            end
            if (d1_wr) begin
                stage_q.vld <= reg_wdata[D1_VLD_BIT];
                stage_q.ctl <= reg_wdata[D1_CTL_LSB +: CTL_W];
                stage_q.sid <= reg_wdata[SID_W-1:0];
            end
            if (d2_wr) begin
                stage_q.rid <= reg_wdata[WORD_W-1 -: RID_W];
                stage_q.msk <= reg_wdata[RID_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_CTRL: begin
                reg_rdata[CTRL_LOAD_BIT] = load_q;
                reg_rdata[IDX_W-1:0]     = idx_q;
            end
            ADR_D1:  reg_rdata = d1_word(stage_q);
            ADR_D2:  reg_rdata = d2_word(stage_q);
            default: reg_rdata = '0;
        endcase
    end

    // R3: a load fills the staging pair from the table's read port
    a_r3_load_fills_stage: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && reg_wdata[CTRL_LOAD_BIT]) |=> (stage_q == $past(rd_entry)));

    // R1: control state is cleared by reset
    a_r1_ctrl_reset: assert property (@(posedge clk)
        $past(rst) |-> (!load_q && idx_q == '0));

endmodule

// File: rtl/rsl_table.sv
module rsl_table
    import rsl_pkg::*;
#(
    parameter int N_ENT = 32,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  rsl_entry_t       wr_entry,
    input  logic [IDX_W-1:0] rd_idx,
    output rsl_entry_t       rd_entry,
    input  logic [RID_W-1:0] lk_rid,
    output logic [N_ENT-1:0] match_vec,
    output rsl_entry_t       ent_o [N_ENT]
);

    rsl_entry_t ent_q [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                ent_q[g] <= wr_entry;
            end
        end
        assign match_vec[g] = rid_match(ent_q[g], lk_rid);
        assign ent_o[g]     = ent_q[g];
    end

    assign rd_entry = ent_q[rd_idx];

    // R4: a committed entry is present in the next cycle
    a_r4_commit_lands: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ent_q[$past(wr_idx)] == $past(wr_entry)));

    // R1: nothing matches right after reset
    a_r1_empty_after_reset: assert property (@(posedge clk)
        $past(rst) |-> (match_vec == '0));

endmodule

// File: rtl/rsl_prio.sv
module rsl_prio #(
    parameter int N_ENT = 32,
    localparam int IDX_W = $clog2(N_ENT)
) (
    input  logic [N_ENT-1:0] match_vec,
    output logic             any,
    output logic [IDX_W-1:0] win_idx,
    output logic [N_ENT-1:0] grant
);

    always_comb begin
        win_idx = '0;
        grant   = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                win_idx = IDX_W'(i);
                grant   = '0;
                grant[i] = 1'b1;
            end
        end
        any = |grant;
    end

    // R8: one winner at most, and no matching entry below it
    always_comb begin
        a_r8_single_winner: assert ($onehot0(grant));
        a_r8_lowest_wins: assert (((grant - 1'b1) & match_vec) == '0 || grant == '0);
        a_r7_any_iff_match: assert (any == (match_vec != '0));
    end

endmodule

// File: rtl/rsl_lut_top.sv
module rsl_lut_top
    import rsl_pkg::*;
#(
    parameter int        N_ENT    = 32,
    parameter src_code_e SRC_CODE = SRC_PCIE_A,
    localparam int IDX_W = $clog2(N_ENT),
    localparam int MSI_W = SID_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              lk_req,
    input  logic [RID_W-1:0]  lk_rid,
    output logic              lk_valid,
    output logic              lk_hit,
    output logic [SID_W-1:0]  lk_sid,
    output logic [CTL_W-1:0]  lk_ctl,
    output logic [MSI_W-1:0]  msi_sid
);

    logic [IDX_W-1:0] rd_idx, commit_idx, win_idx;
    rsl_entry_t       rd_entry, commit_entry, win_ent;
    logic             commit_en, any;
    logic [N_ENT-1:0] match_vec, grant;
    rsl_entry_t       ent [N_ENT];

    rsl_regs #(.N_ENT(N_ENT)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rd_idx(rd_idx), .rd_entry(rd_entry),
        .commit_en(commit_en), .commit_idx(commit_idx), .commit_entry(commit_entry)
    );

    rsl_table #(.N_ENT(N_ENT)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(commit_en), .wr_idx(commit_idx), .wr_entry(commit_entry),
        .rd_idx(rd_idx), .rd_entry(rd_entry),
        .lk_rid(lk_rid), .match_vec(match_vec), .ent_o(ent)
    );

    rsl_prio #(.N_ENT(N_ENT)) u_prio (
        .match_vec(match_vec), .any(any), .win_idx(win_idx), .grant(grant)
    );

    assign win_ent = ent[win_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            lk_valid <= 1'b0;
            lk_hit   <= 1'b0;
            lk_sid   <= '0;
            lk_ctl   <= '0;
            msi_sid  <= '0;
        end else begin
            lk_valid <= lk_req;
            if (lk_req) begin
                lk_hit  <= any;
                lk_sid  <= any ? win_ent.sid : '0;
                lk_ctl  <= any ? win_ent.ctl : '0;
                msi_sid <= any ? {SRC_CODE, win_ent.sid} : '0;
            end
        end
    end

    // R9: result one clock after the strobe
    a_r9_latency: assert property (@(posedge clk) disable iff (rst)
        lk_req |=> lk_valid);

    // R9: all-zero outputs on a miss
    a_r9_miss_zero: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !lk_hit) |-> (lk_sid == '0 && lk_ctl == '0 && msi_sid == '0));

    // R12: the MSI side carries the same StreamID as the IOMMU side
    a_r12_msi_sid_agrees: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_hit) |-> (msi_sid[SID_W-1:0] == lk_sid));

    // R7: a reported hit came from a matching entry
    a_r7_hit_has_match: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && lk_hit) |-> $past(match_vec != '0));

endmodule

// File: tb/sim_rsl_lut_top.sv
module sim_rsl_lut_top;
    import rsl_pkg::*;

    localparam int N = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic lk_req = 1'b0;
    logic [15:0] lk_rid = '0;
    logic lk_valid, lk_hit;
    logic [5:0] lk_sid;
    logic [2:0] lk_ctl;
    logic [7:0] msi_sid;

    always #2.5 clk = ~clk;

    rsl_lut_top #(.N_ENT(N), .SRC_CODE(SRC_PCIE_B)) u0 (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .lk_req(lk_req), .lk_rid(lk_rid), .lk_valid(lk_valid),
        .lk_hit(lk_hit), .lk_sid(lk_sid), .lk_ctl(lk_ctl), .msi_sid(msi_sid)
    );

    int checks = 0;
    int fails = 0;

    // reference model
    logic        m_vld [N];
    logic [2:0]  m_ctl [N];
    logic [5:0]  m_sid [N];
    logic [15:0] m_rid [N];
    logic [15:0] m_msk [N];
    logic [31:0] s_d1 = '0;
    logic [31:0] s_d2 = '0;

    typedef struct {
        logic       hit;
        logic [5:0] sid;
        logic [2:0] ctl;
        logic [7:0] msi;
        string      tag;
    } exp_t;
    exp_t expq[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic exp_t predict(input logic [15:0] rid, input string tag);
        exp_t e;
        e.hit = 1'b0; e.sid = '0; e.ctl = '0; e.msi = '0; e.tag = tag;
        for (int i = N - 1; i >= 0; i--) begin
            if (m_vld[i] && (((rid ^ m_rid[i]) & m_msk[i]) == 16'h0)) begin
                e.hit = 1'b1; e.sid = m_sid[i]; e.ctl = m_ctl[i];
                e.msi = {2'b10, m_sid[i]};
            end
        end
        return e;
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [31:0] d);
        if (a == ADR_D1) s_d1 = d & 32'h8000_073F;
        else if (a == ADR_D2) s_d2 = d;
        else if (a == ADR_CTRL) begin
            int idx = int'(d[4:0]);
            if (d[16]) begin
                s_d1 = {m_vld[idx], 20'h0, m_ctl[idx], 2'b00, m_sid[idx]};
                s_d2 = {m_rid[idx], m_msk[idx]};
            end else begin
                m_vld[idx] = s_d1[31]; m_ctl[idx] = s_d1[10:8]; m_sid[idx] = s_d1[5:0];
                m_rid[idx] = s_d2[31:16]; m_msk[idx] = s_d2[15:0];
            end
        end
    endtask

    task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        model_write(a, d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input logic [15:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic lookup(input logic [15:0] rid, input string tag);
        @(negedge clk);
        lk_req = 1'b1; lk_rid = rid;
        expq.push_back(predict(rid, tag));
        @(negedge clk);
        lk_req = 1'b0;
    endtask

    task automatic put_entry(input int idx, input logic [15:0] rid, input logic [15:0] msk,
                             input logic [5:0] sid, input logic [2:0] ctl);
        reg_write(ADR_D1, {1'b1, 20'h0, ctl, 2'b00, sid});
        reg_write(ADR_D2, {rid, msk});
        reg_write(ADR_CTRL, 32'(idx));
    endtask

    // monitor: pop and compare every result
    always @(negedge clk) begin
        if (!rst && lk_valid) begin
            if (expq.size() == 0) begin
                check("R9 unexpected result", 32'(lk_valid), 32'h0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check({e.tag, " hit"}, 32'(lk_hit), 32'(e.hit));
                check({e.tag, " sid"}, 32'(lk_sid), 32'(e.sid));
                check({e.tag, " ctl"}, 32'(lk_ctl), 32'(e.ctl));
                check({e.tag, " msi R12"}, 32'(msi_sid), 32'(e.msi));
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++; checks++;
            $display("FAIL watchdog actual=%0d expected<100000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_vld[i] = 1'b0; m_ctl[i] = '0; m_sid[i] = '0; m_rid[i] = '0; m_msk[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        reg_check(ADR_CTRL, 32'h0, "R1 ctrl reset");
        reg_check(ADR_D1, 32'h0, "R1 d1 reset");
        reg_check(ADR_D2, 32'h0, "R1 d2 reset");
        lookup(16'h0000, "R1 lookup after reset");

        // R5 / R6 field layouts and reserved bits
        reg_write(ADR_D1, 32'hFFFF_FFFF);
        reg_check(ADR_D1, 32'h8000_073F, "R5 d1 fields");
        reg_write(ADR_D2, 32'hA5C3_5AF0);
        reg_check(ADR_D2, 32'hA5C3_5AF0, "R6 d2 fields");

        // R2 control register: all-ones write is a load of entry 31
        reg_write(ADR_CTRL, 32'hFFFF_FFFF);
        reg_check(ADR_CTRL, 32'h0001_001F, "R2 ctrl readback");
        reg_check(ADR_D1, 32'h0, "R3 load of empty entry d1");
        reg_check(ADR_D2, 32'h0, "R3 load of empty entry d2");

        // R4 populate
        put_entry(3, 16'h0100, 16'hFFFF, 6'd5, 3'd2);
        put_entry(7, 16'h0100, 16'hFF00, 6'd9, 3'd1);
        put_entry(10, 16'h0208, 16'hFFFF, 6'd63, 3'd7);
        reg_check(ADR_CTRL, 32'h0000_000A, "R2 ctrl after commit");

        lookup(16'h0100, "R8 lowest index wins");
        lookup(16'h0105, "R7 masked match");
        lookup(16'h0208, "R4 exact entry max sid");
        lookup(16'h0300, "R9 miss zeros");
        lookup(16'h0209, "R7 unmasked bit differs");

        // R3 load back
        reg_write(ADR_CTRL, 32'h0001_000A);
        reg_check(ADR_D1, 32'h8000_073F, "R3 load d1");
        reg_check(ADR_D2, 32'h0208_FFFF, "R3 load d2");

        // R10 lookup in the same clock as a commit
        reg_write(ADR_D1, 32'h8000_0001);
        reg_write(ADR_D2, 32'h0105_FFFF);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = ADR_CTRL; reg_wdata = 32'h2;
        lk_req = 1'b1; lk_rid = 16'h0105;
        expq.push_back(predict(16'h0105, "R10 old contents"));
        model_write(ADR_CTRL, 32'h2);
        @(negedge clk);
        reg_wr = 1'b0;
        expq.push_back(predict(16'h0105, "R10 new contents"));
        @(negedge clk);
        lk_req = 1'b0;

        // R11 removal
        reg_write(ADR_D1, 32'h0);
        reg_write(ADR_D2, 32'h0);
        reg_write(ADR_CTRL, 32'h3);
        lookup(16'h0100, "R11 removed entry skipped");
        reg_write(ADR_CTRL, 32'h0001_0003);
        reg_check(ADR_D1, 32'h0, "R11 removed d1");
        reg_check(ADR_D2, 32'h0, "R11 removed d2");

        repeat (3) @(negedge clk);
        check("R9 all results seen", 32'(expq.size()), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule